// File: doc/BRIEF.md
# Repeated-Delimiter Frame Extractor

This block sits behind a byte-oriented serial receiver. It takes one byte per accepted strobe and pulls payloads out of the stream. A payload is wrapped in a run of identical opening markers and a run of identical closing markers, and both runs have the same configured depth. Bytes outside a frame are dropped silently. While a payload is open, opening markers count as ordinary data. A closing run that breaks off before reaching full depth is put back into the payload.

Payload bytes leave as a valid/data stream. A one-cycle pulse marks each completed frame. A dedicated flush byte throws away any partial frame and returns the block to hunting for a start. When payload bytes of that frame have already gone out, the flush also raises an abort pulse so that the consumer can drop them.

The three marker bytes and the run depth are run-time inputs. They are meant to be held steady while a frame is in progress.

Top module: `delim_frame_rx`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid`, `frame_done` and `frame_abort` are 0, and the block is hunting for a start with an empty run count.
- R2: While hunting, a byte equal to `cfg_open` increments the run count. Any other byte clears the count. The payload opens on the byte that completes a run of depth consecutive opening markers. No byte received while hunting ever appears on `out_data`.
- R3: Inside a payload, when no closing markers are held, an accepted byte that is neither `cfg_close` nor `cfg_flush` (opening markers included) appears on `out_data` with `out_valid` high in the cycle after it is accepted.
- R4: A run of depth consecutive `cfg_close` bytes inside a payload ends the frame. `frame_done` is high for one cycle, in the cycle after the final closing marker is accepted, and the block returns to hunting. A frame with no payload bytes still gives the pulse, with no data beat before it.
- R5: Suppose k closing markers (1 <= k < depth) are held and the next accepted byte is neither `cfg_close` nor `cfg_flush`. The k markers are then emitted one per cycle, followed by that byte. `in_ready` is 0 for exactly k+1 cycles while this happens, and `out_valid` is 1 in each cycle that follows one of those cycles.
- R6: An accepted `cfg_flush` byte in any state discards the partial frame, including held closing markers, clears the run count and returns to hunting. `frame_abort` pulses in the following cycle only if at least one payload byte of that frame has already been output.
- R7: The depth is `cfg_reps` in the range 1 to 15. A value of 0 behaves exactly like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| cfg_open | input | 8 | Opening marker byte |
| cfg_close | input | 8 | Closing marker byte |
| cfg_flush | input | 8 | Flush byte |
| cfg_reps | input | 4 | Marker run depth (0 taken as 1) |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| frame_done | output | 1 | Frame completed pulse |
| frame_abort | output | 1 | Drop-streamed-bytes pulse |

## Verification
Every depth from 1 to 15 is swept. Each frame is preceded by a one-short opening run that must not open a payload. Inside each frame, every possible partial closing run length is placed between two payload bytes, so that replay length and stall length are checked against the number of held markers. Stream-level cases tell apart the following behaviours:
- opening markers taken as data once a payload is open, against markers that start a frame;
- a flush that arrives after data went out (abort) against one that arrives before any data went out (no abort);
- an empty frame against a dropped one.

A second set of marker bytes confirms that the comparison follows the configuration inputs. A depth of 0 confirms that it behaves like 1.

// File: rtl/delim_frame_rx.sv
module delim_frame_rx #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic [DW-1:0] cfg_open,
  input  logic [DW-1:0] cfg_close,
  input  logic [DW-1:0] cfg_flush,
  input  logic [CW-1:0] cfg_reps,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          frame_done,
  output logic          frame_abort
);

  typedef enum logic [1:0] {S_HUNT, S_BODY, S_REPLAY} st_t;
  localparam logic [CW:0]   ONE_W = 1;
  localparam logic [CW-1:0] ONE   = 1;

  st_t           st;
  logic [CW-1:0] run_q;
  logic [DW-1:0] pend_q;
  logic          sent_q;

  wire [CW-1:0] reps     = (cfg_reps == '0) ? ONE : cfg_reps;
  wire [CW:0]   run_nx   = {1'b0, run_q} + ONE_W;
  wire          run_full = run_nx == {1'b0, reps};
  wire          take     = in_valid && in_ready;
  wire          is_flush = in_data == cfg_flush;
  wire          is_open  = in_data == cfg_open;
  wire          is_close = in_data == cfg_close;

  assign in_ready = st != S_REPLAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_HUNT;
      run_q       <= '0;
      pend_q      <= '0;
      sent_q      <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      frame_done  <= 1'b0;
      frame_abort <= 1'b0;
    end else begin
      out_valid   <= 1'b0;
      frame_done  <= 1'b0;
      frame_abort <= 1'b0;
      case (st)
        S_HUNT: if (take) begin
          if (is_open && !is_flush) begin
            if (run_full) begin
              st     <= S_BODY;
              run_q  <= '0;
              sent_q <= 1'b0;
            end else begin
              run_q <= run_nx[CW-1:0];
            end
          end else begin
            run_q <= '0;
          end
        end
        S_BODY: if (take) begin
          if (is_flush) begin
            st          <= S_HUNT;
            run_q       <= '0;
            frame_abort <= sent_q;
            sent_q      <= 1'b0;
          end else if (is_close) begin
            if (run_full) begin
              st         <= S_HUNT;
              run_q      <= '0;
              frame_done <= 1'b1;
              sent_q     <= 1'b0;
            end else begin
              run_q <= run_nx[CW-1:0];
            end
          end else if (run_q == '0) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
            sent_q    <= 1'b1;
          end else begin
            st     <= S_REPLAY;
            pend_q <= in_data;
          end
        end
        S_REPLAY: begin
          out_valid <= 1'b1;
          sent_q    <= 1'b1;
          if (run_q != '0) begin
            out_data <= cfg_close;
            run_q    <= run_q - ONE;
          end else begin
            out_data <= pend_q;
            st       <= S_BODY;
          end
        end
        default: st <= S_HUNT;
      endcase
    end
  end

  a_r4_done_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(in_valid && in_ready && in_data == cfg_close));

  a_r4_done_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && out_valid));

  a_r6_abort_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> $past(in_valid && in_ready && in_data == cfg_flush));

  a_r6_abort_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_abort && frame_done));

  a_r5_stall_emits: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_valid);

  a_r2_hunt_silent: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(st != S_HUNT));

endmodule

// File: tb/tb_delim_frame_rx.sv
`timescale 1ns/1ps
module tb_delim_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic [7:0] cfg_open = 8'h5B, cfg_close = 8'h5D, cfg_flush = 8'h21;
  logic [3:0] cfg_reps = 4'd3;
  logic       out_valid, frame_done, frame_abort;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  delim_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cfg_open(cfg_open), .cfg_close(cfg_close),
    .cfg_flush(cfg_flush), .cfg_reps(cfg_reps), .out_valid(out_valid),
    .out_data(out_data), .frame_done(frame_done), .frame_abort(frame_abort)
  );

  int total = 0, bad = 0, aborts = 0, stall = 0;
  bit finished = 0;
  string got = "";
  string frames[$];

  always @(negedge clk) if (rst_n) begin
    if (!in_ready) stall++;
    if (out_valid) got = {got, $sformatf("%c", out_data)};
    if (frame_done) begin frames.push_back(got); got = ""; end
    if (frame_abort) begin aborts++; got = ""; end
  end

  task automatic chk(string req, bit ok, string act, string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    chk(req, act == exp, $sformatf("%0d", act), $sformatf("%0d", exp));
  endtask

  task automatic send(logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_str(string s);
    for (int i = 0; i < s.len(); i++) send(s[i]);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear();
    frames.delete();
    got = "";
    aborts = 0;
    stall = 0;
  endtask

  task automatic chk_frames1(string req, string exp);
    chk_int(req, frames.size(), 1);
    if (frames.size() == 1) chk(req, frames[0] == exp, frames[0], exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_int("R1 in_ready", int'(in_ready), 1);
    chk_int("R1 out_valid", int'(out_valid), 0);
    chk_int("R1 frame_done", int'(frame_done), 0);
    chk_int("R1 frame_abort", int'(frame_abort), 0);

    // R2 R4 R6: stray bytes and flush between frames
    clear();
    send_str("x[[[hello]]]![[[world]]]ab");
    idle(4);
    chk_int("R2 frame count", frames.size(), 2);
    if (frames.size() == 2) begin
      chk("R2 first frame", frames[0] == "hello", frames[0], "hello");
      chk("R4 second frame", frames[1] == "world", frames[1], "world");
    end
    chk_int("R6 no abort between frames", aborts, 0);
    chk("R2 stray bytes silent", got == "", got, "");

    // R3 R5: opening markers as data, broken closing runs replayed
    clear();
    send_str("x[y[[z[[[[[[[[[foo]1]]2]]]3");
    idle(4);
    chk_frames1("R3 nested opens", "[[[[[[foo]1]]2");
    chk("R2 trailing byte silent", got == "", got, "");

    // R3 output timing
    clear();
    send_str("[[[");
    send("h");
    chk("R3 beat timing", out_valid && out_data == "h",
        $sformatf("%0d/%02h", out_valid, out_data), "1/68");
    send_str("i]]");
    send("]");
    chk_int("R4 done timing", int'(frame_done), 1);
    idle(2);
    chk_frames1("R3 frame hi", "hi");

    // R4 empty frame
    clear();
    send_str("[[[]]");
    send("]");
    chk_int("R4 empty done", int'(frame_done), 1);
    idle(2);
    chk_frames1("R4 empty frame", "");

    // R6 flush cases
    clear();
    send_str("[[[ab");
    send("!");
    chk_int("R6 abort pulse", int'(frame_abort), 1);
    idle(2);
    chk_int("R6 no frame after abort", frames.size(), 0);
    send_str("[[[!");
    idle(2);
    chk_int("R6 no abort before data", aborts, 1);
    send_str("[[[]]!");
    idle(2);
    chk_int("R6 held closes dropped abort", aborts, 1);
    chk("R6 held closes dropped data", got == "", got, "");
    send_str("[[![e]]]");
    idle(2);
    chk_int("R6 run cleared by flush", frames.size(), 0);
    chk("R6 run cleared data", got == "", got, "");
    send_str("[[[cd]]]");
    idle(2);
    chk_frames1("R6 recovery", "cd");

    // R7 depth 0 acts as 1
    clear();
    cfg_reps = 4'd0;
    send_str("x[a]");
    idle(2);
    chk_frames1("R7 depth0 frame", "a");
    clear();
    send_str("[]");
    idle(2);
    chk_frames1("R7 depth0 empty", "");

    // R3 R5 alternate markers follow configuration
    clear();
    cfg_open = "<"; cfg_close = ">"; cfg_flush = "#"; cfg_reps = 4'd2;
    send_str("[[<<a[]>b>>");
    idle(2);
    chk_frames1("R3 alt markers", "a[]>b");
    chk_int("R5 alt stall", stall, 2);
    cfg_open = 8'h5B; cfg_close = 8'h5D; cfg_flush = 8'h21;

    // R2 R5 sweep over depth and held length
    for (int n = 1; n <= 15; n++) begin
      cfg_reps = 4'(n);
      for (int k = 0; k < n; k++) begin
        string s, e;
        clear();
        s = "";
        repeat (n - 1) s = {s, "["};
        s = {s, "x"};
        repeat (n) s = {s, "["};
        s = {s, "q"};
        e = "q";
        repeat (k) begin s = {s, "]"}; e = {e, "]"}; end
        s = {s, "z"};
        e = {e, "z"};
        repeat (n - 1) s = {s, "]"};
        send_str(s);
        send("]");
        chk_int($sformatf("R4 sweep done n=%0d k=%0d", n, k), int'(frame_done), 1);
        idle(2);
        chk_frames1($sformatf("R5 sweep n=%0d k=%0d", n, k), e);
        chk_int($sformatf("R5 sweep stall n=%0d k=%0d", n, k), stall, (k > 0) ? k + 1 : 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule